// File: doc/BRIEF.md
# Synchronizable Codec Clock Divider

This block derives the host-facing timing of a converter from one fast master clock. From the master clock it produces four outputs. The converter clock and the serial clock are the master clock divided by eight. The sample strobe is divided by sixteen, or by eight when the fast-rate pin is set. A keep-out flag is high for the one master cycle that comes before each edge of the converter clock. Host logic uses this flag to keep its own I/O quiet while analog sampling takes place.

All outputs come from a single phase counter, so their relative phase is fixed. Several devices can share a sync line. When a device samples a rising sync pulse, its counter restarts from a known phase. The outputs of every device then rise together a fixed four master cycles later. Release of reset starts the counter in the same way, so a device that has only just left reset lines up with devices that have been running.

Top module: `codec_clk_gen`

## Requirements
- R1: While `rstN` is low, `clkOut`, `sclkOut`, `intOut` and `kozFlag` are all 0.
- R2: When no realignment occurs, `clkOut` has a period of 8 master cycles: 4 cycles high, then 4 cycles low.
- R3: `sclkOut` equals `clkOut` in every cycle. It runs continuously and needs no other activity.
- R4: With `osEn` = 0, `intOut` has a period of 16 master cycles, 8 high then 8 low. Its rising edges coincide with every second rising edge of `clkOut`.
- R5: With `osEn` = 1, `intOut` equals `clkOut`, the value of `osEn` being taken at the edge that updates the outputs.
- R6: An alignment edge is a master edge at which `syncIn` is 1 after it was 0 at the previous edge. At an alignment edge, `clkOut` and `intOut` go or stay low. They remain low for the next three edges and rise on the fourth edge after it.
- R7: Holding `syncIn` high for several cycles realigns only once, at its first sampled-high edge. After that the counter runs free.
- R8: `kozFlag` is high for exactly one master cycle, the cycle that ends with an edge at which `clkOut` changes in free run. One such cycle occurs every 4 master cycles. It is also high in the cycle just before the first rise after an alignment.
- R9: The first master edge after `rstN` goes high counts as an alignment edge, so the first `clkOut` rise comes on the fourth edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| osEn | input | 1 | 1 selects the fast sample strobe (divide by 8) |
| syncIn | input | 1 | Shared alignment pulse, normally low |
| intOut | output | 1 | Sample-rate strobe |
| clkOut | output | 1 | Converter clock, master divided by 8 |
| sclkOut | output | 1 | Serial clock, in phase with `clkOut` |
| kozFlag | output | 1 | High in the master cycle before a `clkOut` edge |

## Verification
Every output is registered once after the phase counter, so each output reflects the edge just taken. An alignment edge sets the outputs low at once. The rise is due on the fourth edge after it, and the keep-out flag is due on the third. The bench counts edges from the most recent alignment edge, which it identifies from its own drive of `syncIn` and reset. From that count it computes each output value arithmetically. It samples one nanosecond after every rising edge and sweeps a single-cycle sync pulse over all sixteen counter phases in both strobe modes.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  // strobes from the alignment control to the divider datapath
  typedef struct packed {
    logic load;   // restart the phase counter at its alignment value
  } divStrobe_t;
endpackage

// File: rtl/codec_clk_ctrl.sv
module codec_clk_ctrl
  import codec_clk_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       syncIn,
  output divStrobe_t strobe
);
  logic syncQ;     // syncIn as seen at the previous edge
  logic armed;     // first edge after reset still pending
  logic syncRise;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 1'b0;
      armed <= 1'b1;
    end else begin
      syncQ <= syncIn;
      armed <= 1'b0;
    end
  end

  always_comb begin
    syncRise    = syncIn & ~syncQ;
    strobe.load = armed | syncRise;
  end

  // R7: a sync level that is still high one edge after a load never reloads
  p_single_trigger_r7: assert property (@(posedge clkIn) disable iff (!rstN)
    (strobe.load && syncIn) |=> !strobe.load);
endmodule

// File: rtl/codec_clk_dp.sv
module codec_clk_dp
  import codec_clk_pkg::*;
#(
  parameter int CNT_W = 4,   // phase counter width; clkOut divides by 2**(CNT_W-1)
  parameter int LAT   = 4    // edges from alignment to first rise
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       osEn,
  input  divStrobe_t strobe,
  output logic       intOut,
  output logic       clkOut,
  output logic       sclkOut,
  output logic       kozFlag
);
  localparam int TOP_BIT = CNT_W - 1;
  localparam int MID_BIT = CNT_W - 2;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'((1 << CNT_W) - LAT);

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] phaseNext;

  always_comb begin
    if (strobe.load) phaseNext = LOAD_VAL;
    else             phaseNext = phase + CNT_W'(1);
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      clkOut  <= 1'b0;
      sclkOut <= 1'b0;
      intOut  <= 1'b0;
      kozFlag <= 1'b0;
    end else begin
      phase   <= phaseNext;
      clkOut  <= ~phaseNext[MID_BIT];
      sclkOut <= ~phaseNext[MID_BIT];
      intOut  <= osEn ? ~phaseNext[MID_BIT] : ~phaseNext[TOP_BIT];
      kozFlag <= &phaseNext[MID_BIT-1:0];
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clkIn)
    !rstN |-> (!clkOut && !sclkOut && !intOut && !kozFlag));

  p_sclk_track_r3: assert property (@(posedge clkIn) disable iff (!rstN)
    sclkOut == clkOut);

  p_fast_int_r5: assert property (@(posedge clkIn) disable iff (!rstN)
    $past(osEn) |-> (intOut == clkOut));

  p_load_low_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    strobe.load |=> (!clkOut && !intOut));

  p_koz_edge_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    (kozFlag && !strobe.load) |=> (clkOut != $past(clkOut)));
endmodule

// File: rtl/codec_clk_gen.sv
module codec_clk_gen
  import codec_clk_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LAT   = 4
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic osEn,
  input  logic syncIn,
  output logic intOut,
  output logic clkOut,
  output logic sclkOut,
  output logic kozFlag
);
  divStrobe_t strobe;

  codec_clk_ctrl u_ctrl (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .syncIn (syncIn),
    .strobe (strobe)
  );

  codec_clk_dp #(.CNT_W(CNT_W), .LAT(LAT)) u_dp (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .osEn    (osEn),
    .strobe  (strobe),
    .intOut  (intOut),
    .clkOut  (clkOut),
    .sclkOut (sclkOut),
    .kozFlag (kozFlag)
  );
endmodule

// File: tb/sim_codec_clk_gen.sv
module sim_codec_clk_gen;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic osEn = 1'b0;
  logic syncIn = 1'b0;
  logic intOut, clkOut, sclkOut, kozFlag;

  int nChecked = 0;
  int nFailed = 0;
  bit finished = 1'b0;

  // bench model state
  int  edgeN = 0;        // edges since last alignment edge
  bit  armedM = 1'b1;
  bit  syncPrevM = 1'b0;

  always #2.5 clk = ~clk;

  codec_clk_gen u0 (
    .clkIn(clk), .rstN(rstN), .osEn(osEn), .syncIn(syncIn),
    .intOut(intOut), .clkOut(clkOut), .sclkOut(sclkOut), .kozFlag(kozFlag)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    nChecked++;
    if (got !== exp) begin
      nFailed++;
      $display("FAIL %s %s: got %b expected %b (edge %0d)", tag, what, got, exp, edgeN);
    end
  endtask

  // one master edge with the design out of reset
  task automatic step(input string ctx);
    bit ld, ck, sl, kz, ex;
    @(posedge clk);
    ld = armedM || (syncIn && !syncPrevM);
    armedM = 1'b0;
    syncPrevM = syncIn;
    if (ld) edgeN = 0; else edgeN++;
    ck = (edgeN >= 4) && (((edgeN - 4) % 8) < 4);
    sl = (edgeN >= 4) && (((edgeN - 4) % 16) < 8);
    kz = (edgeN == 3) || ((edgeN >= 4) && (((edgeN - 4) % 4) == 3));
    ex = osEn ? ck : sl;
    #1;
    chk({ctx, "/R2"}, "clkOut", clkOut, ck);
    chk({ctx, "/R3"}, "sclkOut", sclkOut, ck);
    chk({ctx, osEn ? "/R5" : "/R4"}, "intOut", intOut, ex);
    chk({ctx, "/R8"}, "kozFlag", kozFlag, kz);
  endtask

  task automatic resetCycles(input int n);
    @(negedge clk);
    rstN = 1'b0;
    armedM = 1'b1;
    syncPrevM = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      // R1: all outputs quiet in reset
      chk("R1", "clkOut", clkOut, 1'b0);
      chk("R1", "sclkOut", sclkOut, 1'b0);
      chk("R1", "intOut", intOut, 1'b0);
      chk("R1", "kozFlag", kozFlag, 1'b0);
    end
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      nFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end

  initial begin
    // R1 and R9: reset, then the first edge aligns
    resetCycles(5);
    for (int i = 0; i < 40; i++) step("R9");

    // R5 fast strobe in free run
    @(negedge clk); osEn = 1'b1;
    for (int i = 0; i < 40; i++) step("R5");

    // R6: single-cycle sync swept over every counter phase, both modes
    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < 16; off++) begin
        @(negedge clk); osEn = (m == 1);
        for (int i = 0; i < off; i++) step("R6");
        @(negedge clk); syncIn = 1'b1;
        step("R6");
        @(negedge clk); syncIn = 1'b0;
        for (int i = 0; i < 24; i++) step("R6");
      end
    end

    // R7: sync held high realigns once
    @(negedge clk); osEn = 1'b0;
    for (int i = 0; i < 5; i++) step("R7");
    @(negedge clk); syncIn = 1'b1;
    for (int i = 0; i < 21; i++) step("R7");
    @(negedge clk); syncIn = 1'b0;
    for (int i = 0; i < 20; i++) step("R7");

    // R1/R9 again mid-run, with sync held high across release
    @(negedge clk); syncIn = 1'b1;
    resetCycles(3);
    for (int i = 0; i < 6; i++) step("R9");
    @(negedge clk); syncIn = 1'b0;
    for (int i = 0; i < 30; i++) step("R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end
endmodule